// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a host that only performs 64-bit register accesses a path onto a peripheral bus with 32-bit addresses. The host sees four 8-byte registers: control, reset, status and data. A single write to the control register launches a complete bus transaction. That write supplies the direction, the byte count and the 32-bit target address. For a bus write, the payload comes from the data register.

When the transaction completes, the outcome appears in the status register. Read data is packed into the middle of the status word, next to a done flag. A failed read returns all ones in that field. The status register clears itself when the host reads it.

The host port is a plain strobe interface. Read data is combinational in the same cycle as the strobe. The bus side uses two valid/ready channels:

- **Request channel.** Once `bus_req_valid` rises, the request fields hold steady until the cycle in which `bus_req_ready` is high. Back-pressure from the bus is absorbed for as long as it lasts.
- **Response channel.** `bus_rsp_ready` is high only while the bridge waits for a response. A response is taken in a cycle where `bus_rsp_valid` and `bus_rsp_ready` are both high.

Only one transaction is outstanding at a time.

Top module: `ibr_top`

## Requirements
- R1: Only host accesses with `host_size` equal to 8 are accepted. An access of any other size reads as zero and changes no state. The register index is `host_addr[4:3]`: 0 is control, 1 is reset, 2 is status and 3 is data.
- R2: A control write issued while idle, with a byte count of at most 8, launches one bus request in the next cycle. The request fields are:
  - address: control bits [31:0];
  - write flag: the inverse of control bit 48 (bit 48 set means read);
  - byte count: control bits [59:56], where 0 and 8 are both legal;
  - write data: the data register as it stood at launch.
- R3: A control write with a byte count above 8 issues no request and leaves the status register unchanged.
- R4: When a read response without error is accepted, status becomes the done flag at bit 11 with the 32 read bits in [57:26]. The first byte (`bus_rsp_rdata[31:24]`) lands in the most significant position.
- R5: When a read response with error is accepted, status becomes the done flag plus all ones in [57:26].
- R6: When a write response is accepted, status becomes exactly the done flag (0x800), whatever the error flag says.
- R7: A status read returns the current value and clears the register to zero at the same edge. A completion landing on that same edge wins, and its value is kept.
- R8: A data-register write stores `host_wdata[63:32]`. A data-register read returns the stored value in [63:32] with zeros below.
- R9: Reads of the control and reset registers return zero. Writes to the reset and status registers have no effect.
- R10: A request holds valid and all of its fields stable until `bus_req_ready`. Control writes made while a transaction is in flight are ignored.
- R11: After the request handshake, `bus_rsp_ready` is high until a response is accepted. The new status is readable in the cycle after acceptance.
- R12: After reset, status and data are zero and no request or response handshake is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Host byte address; bits [4:3] select the register |
| host_size | input | 4 | Access size in bytes; only 8 is accepted |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, valid in the strobe cycle |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_addr | output | 32 | Bus target address |
| bus_req_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_req_bytes | output | 4 | Byte count of the transaction |
| bus_req_wdata | output | 32 | Bus write data, first byte in [31:24] |
| bus_rsp_valid | input | 1 | Bus response valid |
| bus_rsp_ready | output | 1 | Bridge waits for a response |
| bus_rsp_rdata | input | 32 | Read data from the bus |
| bus_rsp_err | input | 1 | Bus reports the transaction failed |

## Verification
The hardest situation to reach from the ports is a status read that lands on the same edge as a response being accepted. The bench creates it by holding the response back until it can raise `bus_rsp_valid` in the very cycle it strobes a status read. It then checks two things: the read returns the old value, and the following read returns the completion.

Control writes issued while the request is held back by a low `bus_req_ready`, and oversize byte counts issued after a read has filled status, cover the other cases that are easy to miss. Both show up only as an absent request or an unchanged status.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int HOST_DW       = 64;
  localparam int BUS_AW        = 32;
  localparam int BUS_DW        = 32;
  localparam int CNT_W         = 4;
  localparam int SIZE_W        = 4;
  localparam int ACC_BYTES     = 8;
  localparam int MAX_BYTES     = 8;
  localparam int NUM_REGS      = 4;
  localparam int IDX_LSB       = 3;
  localparam int IDX_W         = $clog2(NUM_REGS);
  localparam int CTL_RD_BIT    = 48;
  localparam int CTL_CNT_LSB   = 56;
  localparam int STAT_DONE_BIT = 11;
  localparam int STAT_DATA_LSB = 26;
  localparam int DATA_HI_LSB   = HOST_DW - BUS_DW;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTL  = 2'd0,
    IDX_RST  = 2'd1,
    IDX_STAT = 2'd2,
    IDX_DATA = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic [BUS_AW-1:0] addr;
    logic              write;
    logic [CNT_W-1:0]  bytes;
    logic [BUS_DW-1:0] wdata;
  } bus_cmd_t;

  function automatic logic [HOST_DW-1:0] done_word(input logic with_data,
                                                   input logic [BUS_DW-1:0] d);
    logic [HOST_DW-1:0] w;
    w = '0;
    w[STAT_DONE_BIT] = 1'b1;
    if (with_data) w[STAT_DATA_LSB +: BUS_DW] = d;
    return w;
  endfunction
endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
  import ibr_pkg::*;
#(
  parameter int HOST_AW = 6
) (
  input  logic                host_req,
  input  logic                host_we,
  input  logic [HOST_AW-1:0]  host_addr,
  input  logic [SIZE_W-1:0]   host_size,
  input  logic [HOST_DW-1:0]  host_wdata,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic                cmd_ok,
  output bus_cmd_t            cmd
);
  logic             acc_ok;
  logic [IDX_W-1:0] idx;

  assign acc_ok = host_req && (host_size == SIZE_W'(ACC_BYTES));
  assign idx    = host_addr[IDX_LSB +: IDX_W];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel[i] = acc_ok &&  host_we && (idx == IDX_W'(i));
    assign rd_sel[i] = acc_ok && !host_we && (idx == IDX_W'(i));
  end

  always_comb begin
    cmd       = '0;
    cmd.addr  = host_wdata[BUS_AW-1:0];
    cmd.write = !host_wdata[CTL_RD_BIT];
    cmd.bytes = host_wdata[CTL_CNT_LSB +: CNT_W];
  end

  assign cmd_ok = (cmd.bytes <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/ibr_master.sv
module ibr_master
  import ibr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  bus_cmd_t          cmd_in,
  input  logic [BUS_DW-1:0] wdata_in,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [BUS_AW-1:0] bus_req_addr,
  output logic              bus_req_write,
  output logic [CNT_W-1:0]  bus_req_bytes,
  output logic [BUS_DW-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  output logic              bus_rsp_ready,
  output logic              cmpl_valid,
  output logic              cmpl_write
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} state_e;

  state_e   state_q;
  bus_cmd_t cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch) begin
          cmd_q       <= cmd_in;
          cmd_q.wdata <= wdata_in;
          state_q     <= ST_REQ;
        end
        ST_REQ:  if (bus_req_ready) state_q <= ST_RSP;
        ST_RSP:  if (bus_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_valid = (state_q == ST_REQ);
  assign bus_rsp_ready = (state_q == ST_RSP);
  assign bus_req_addr  = cmd_q.addr;
  assign bus_req_write = cmd_q.write;
  assign bus_req_bytes = cmd_q.bytes;
  assign bus_req_wdata = cmd_q.wdata;
  assign cmpl_valid    = bus_rsp_ready && bus_rsp_valid;
  assign cmpl_write    = cmd_q.write;
endmodule

// File: rtl/ibr_regs.sv
module ibr_regs
  import ibr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] wr_sel,
  input  logic [NUM_REGS-1:0] rd_sel,
  input  logic [HOST_DW-1:0]  host_wdata,
  input  logic                cmpl_valid,
  input  logic                cmpl_write,
  input  logic                cmpl_err,
  input  logic [BUS_DW-1:0]   cmpl_rdata,
  output logic [BUS_DW-1:0]   data_q,
  output logic [HOST_DW-1:0]  stat_q,
  output logic [HOST_DW-1:0]  host_rdata
);
  logic [HOST_DW-1:0] cmpl_word;

  always_comb begin
    if (cmpl_write)    cmpl_word = done_word(1'b0, '0);
    else if (cmpl_err) cmpl_word = done_word(1'b1, '1);
    else               cmpl_word = done_word(1'b1, cmpl_rdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_sel[IDX_DATA]) data_q <= host_wdata[DATA_HI_LSB +: BUS_DW];
      if (cmpl_valid)             stat_q <= cmpl_word;
      else if (rd_sel[IDX_STAT])  stat_q <= '0;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (rd_sel[IDX_STAT]) host_rdata = stat_q;
    if (rd_sel[IDX_DATA]) host_rdata = {data_q, {DATA_HI_LSB{1'b0}}};
  end
endmodule

// File: rtl/ibr_top.sv
module ibr_top
  import ibr_pkg::*;
#(
  parameter int HOST_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [SIZE_W-1:0]  host_size,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               bus_req_valid,
  input  logic               bus_req_ready,
  output logic [BUS_AW-1:0]  bus_req_addr,
  output logic               bus_req_write,
  output logic [CNT_W-1:0]   bus_req_bytes,
  output logic [BUS_DW-1:0]  bus_req_wdata,
  input  logic               bus_rsp_valid,
  output logic               bus_rsp_ready,
  input  logic [BUS_DW-1:0]  bus_rsp_rdata,
  input  logic               bus_rsp_err
);
  logic [NUM_REGS-1:0] wr_sel, rd_sel;
  logic                cmd_ok;
  bus_cmd_t            dec_cmd;
  logic [BUS_DW-1:0]   data_w;
  logic [HOST_DW-1:0]  stat_w;
  logic                cmpl_valid, cmpl_write;

  ibr_decode #(.HOST_AW(HOST_AW)) u_dec (
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_size(host_size), .host_wdata(host_wdata),
    .wr_sel(wr_sel), .rd_sel(rd_sel), .cmd_ok(cmd_ok), .cmd(dec_cmd)
  );

  ibr_master u_mst (
    .clk(clk), .rst_n(rst_n),
    .launch(wr_sel[IDX_CTL] && cmd_ok), .cmd_in(dec_cmd), .wdata_in(data_w),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_addr(bus_req_addr), .bus_req_write(bus_req_write),
    .bus_req_bytes(bus_req_bytes), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_ready(bus_rsp_ready),
    .cmpl_valid(cmpl_valid), .cmpl_write(cmpl_write)
  );

  ibr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .rd_sel(rd_sel),
    .host_wdata(host_wdata), .cmpl_valid(cmpl_valid), .cmpl_write(cmpl_write),
    .cmpl_err(bus_rsp_err), .cmpl_rdata(bus_rsp_rdata),
    .data_q(data_w), .stat_q(stat_w), .host_rdata(host_rdata)
  );
endmodule

// File: rtl/ibr_checker.sv
module ibr_checker
  import ibr_pkg::*;
#(
  parameter int HOST_AW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_req,
  input logic               host_we,
  input logic [HOST_AW-1:0] host_addr,
  input logic [SIZE_W-1:0]  host_size,
  input logic [HOST_DW-1:0] host_wdata,
  input logic               bus_req_valid,
  input logic               bus_req_ready,
  input logic [BUS_AW-1:0]  bus_req_addr,
  input logic               bus_req_write,
  input logic [CNT_W-1:0]   bus_req_bytes,
  input logic [BUS_DW-1:0]  bus_req_wdata,
  input logic               bus_rsp_valid,
  input logic               bus_rsp_ready,
  input logic [BUS_DW-1:0]  bus_rsp_rdata,
  input logic               bus_rsp_err,
  input logic [HOST_DW-1:0] stat_w
);
  logic acc8, stat_rd, ctl_wr_big, take_rsp;
  assign acc8       = host_req && host_size == SIZE_W'(ACC_BYTES);
  assign stat_rd    = acc8 && !host_we && host_addr[IDX_LSB +: IDX_W] == IDX_STAT;
  assign ctl_wr_big = acc8 && host_we && host_addr[IDX_LSB +: IDX_W] == IDX_CTL
                      && host_wdata[CTL_CNT_LSB +: CNT_W] > CNT_W'(MAX_BYTES);
  assign take_rsp   = bus_rsp_valid && bus_rsp_ready;

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_write) && $stable(bus_req_bytes) && $stable(bus_req_wdata));

  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req_valid && bus_rsp_ready));

  a_r11_wait_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_ready |=> bus_rsp_ready);

  a_r4_read_ok: assert property (@(posedge clk) disable iff (!rst_n)
    take_rsp && !bus_req_write && !bus_rsp_err |=>
      stat_w == {6'b0, $past(bus_rsp_rdata), 14'b0, 1'b1, 11'b0});

  a_r5_read_fail: assert property (@(posedge clk) disable iff (!rst_n)
    take_rsp && !bus_req_write && bus_rsp_err |=>
      stat_w == {6'b0, 32'hFFFF_FFFF, 14'b0, 1'b1, 11'b0});

  a_r6_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    take_rsp && bus_req_write |=> stat_w == 64'h800);

  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !take_rsp |=> stat_w == '0);

  a_r3_oversize_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_big && !bus_req_valid && !bus_rsp_ready |=> !bus_req_valid && $stable(stat_w));
endmodule

bind ibr_top ibr_checker #(.HOST_AW(HOST_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_req_addr(bus_req_addr), .bus_req_write(bus_req_write),
  .bus_req_bytes(bus_req_bytes), .bus_req_wdata(bus_req_wdata),
  .bus_rsp_valid(bus_rsp_valid), .bus_rsp_ready(bus_rsp_ready),
  .bus_rsp_rdata(bus_rsp_rdata), .bus_rsp_err(bus_rsp_err), .stat_w(stat_w)
);

// File: tb/ibr_top_tb.sv
module ibr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 0, host_we = 0;
  logic [5:0]  host_addr = '0;
  logic [3:0]  host_size = 4'd8;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        bus_req_valid, bus_req_write, bus_rsp_ready;
  logic        bus_req_ready = 0, bus_rsp_valid = 0, bus_rsp_err = 0;
  logic [31:0] bus_req_addr, bus_req_wdata;
  logic [31:0] bus_rsp_rdata = '0;
  logic [3:0]  bus_req_bytes;

  int vectors = 0, misses = 0;
  logic done_flag = 0;

  always #10 clk = ~clk;

  ibr_top u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .bus_req_valid(bus_req_valid),
    .bus_req_ready(bus_req_ready), .bus_req_addr(bus_req_addr),
    .bus_req_write(bus_req_write), .bus_req_bytes(bus_req_bytes),
    .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_ready(bus_rsp_ready), .bus_rsp_rdata(bus_rsp_rdata),
    .bus_rsp_err(bus_rsp_err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_phase;
  logic [31:0] m_addr, m_wd, m_data;
  logic        m_wr;
  logic [3:0]  m_cnt;
  logic [63:0] m_stat;
  logic        m_ok;
  int          m_old;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_addr = 0; m_wd = 0; m_data = 0; m_wr = 0; m_cnt = 0; m_stat = 0;
    end else begin
      m_ok  = host_req && host_size == 4'd8;
      m_old = m_phase;
      if (m_old == 2 && bus_rsp_valid) begin
        if (m_wr)             m_stat = 64'h800;
        else if (bus_rsp_err) m_stat = (64'hFFFF_FFFF << 26) | 64'h800;
        else                  m_stat = (64'(bus_rsp_rdata) << 26) | 64'h800;
        m_phase = 0;
      end else if (m_ok && !host_we && host_addr[4:3] == 2'd2) begin
        m_stat = 0;
      end
      if (m_old == 1 && bus_req_ready) m_phase = 2;
      if (m_old == 0 && m_ok && host_we && host_addr[4:3] == 2'd0
          && host_wdata[59:56] <= 4'd8) begin
        m_addr = host_wdata[31:0]; m_wr = !host_wdata[48];
        m_cnt = host_wdata[59:56]; m_wd = m_data; m_phase = 1;
      end
      if (m_ok && host_we && host_addr[4:3] == 2'd3) m_data = host_wdata[63:32];
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic [63:0] e;
    #2;
    if (rst_n && !done_flag) begin
      chk("R10 req_valid", {63'b0, bus_req_valid}, {63'b0, m_phase == 1});
      chk("R11 rsp_ready", {63'b0, bus_rsp_ready}, {63'b0, m_phase == 2});
      if (m_phase == 1) begin
        chk("R2 addr",  {32'b0, bus_req_addr},  {32'b0, m_addr});
        chk("R2 write", {63'b0, bus_req_write}, {63'b0, m_wr});
        chk("R2 bytes", {60'b0, bus_req_bytes}, {60'b0, m_cnt});
        chk("R2 wdata", {32'b0, bus_req_wdata}, {32'b0, m_wd});
      end
      e = 0;
      if (host_req && !host_we && host_size == 4'd8) begin
        if (host_addr[4:3] == 2'd2) e = m_stat;
        if (host_addr[4:3] == 2'd3) e = {m_data, 32'b0};
      end
      chk("R7/R8/R9 rdata", host_rdata, e);
    end
  end

  task automatic host_wr(logic [1:0] idx, logic [63:0] v, logic [3:0] sz = 4'd8);
    host_req = 1; host_we = 1; host_addr = {1'b0, idx, 3'b0}; host_size = sz; host_wdata = v;
    @(negedge clk);
    host_req = 0; host_we = 0; host_size = 4'd8; host_wdata = 0;
  endtask

  task automatic host_rd(logic [1:0] idx, output logic [63:0] v, input logic [3:0] sz = 4'd8);
    host_req = 1; host_we = 0; host_addr = {1'b0, idx, 3'b0}; host_size = sz;
    #1 v = host_rdata;
    @(negedge clk);
    host_req = 0; host_size = 4'd8;
  endtask

  task automatic serve(int req_delay, int rsp_delay, logic [31:0] rd, logic err);
    #1;
    while (!bus_req_valid) begin @(negedge clk); #1; end
    repeat (req_delay) @(negedge clk);
    bus_req_ready = 1; @(negedge clk); bus_req_ready = 0;
    repeat (rsp_delay) @(negedge clk);
    bus_rsp_valid = 1; bus_rsp_rdata = rd; bus_rsp_err = err;
    @(negedge clk);
    bus_rsp_valid = 0; bus_rsp_err = 0;
  endtask

  function automatic logic [63:0] ctl(logic rd, logic [3:0] n, logic [31:0] a);
    return (64'(rd) << 48) | (64'(n) << 56) | 64'(a);
  endfunction

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    host_rd(2'd2, v); chk("R12 status after reset", v, 64'h0);
    host_rd(2'd3, v); chk("R12 data after reset", v, 64'h0);

    host_wr(2'd3, 64'hA1B2_C3D4_5555_6666);
    host_rd(2'd3, v); chk("R8 data readback", v, 64'hA1B2_C3D4_0000_0000);

    // bus write under back-pressure, failing response
    host_wr(2'd0, ctl(0, 4'd4, 32'h1234_5678));
    #1 chk("R2 write request data", {32'b0, bus_req_wdata}, 64'hA1B2_C3D4);
    serve(3, 1, 32'h0, 1'b1);
    host_rd(2'd2, v); chk("R6 write done despite error", v, 64'h800);
    host_rd(2'd2, v); chk("R7 cleared after read", v, 64'h0);

    // bus read with an ignored control write while busy
    host_wr(2'd0, ctl(1, 4'd4, 32'hCAFE_0000));
    host_wr(2'd0, ctl(0, 4'd2, 32'h0BAD_0BAD));
    #1 chk("R10 address unchanged while busy", {32'b0, bus_req_addr}, 64'hCAFE_0000);
    serve(0, 2, 32'hDEAD_BEEF, 1'b0);
    #1 chk("R10 no further request", {63'b0, bus_req_valid}, 64'h0);
    host_rd(2'd2, v); chk("R4 read data packed", v, (64'hDEAD_BEEF << 26) | 64'h800);

    // failed read
    host_wr(2'd0, ctl(1, 4'd1, 32'h0000_0010));
    serve(1, 0, 32'h1111_1111, 1'b1);
    host_rd(2'd2, v); chk("R5 failed read all ones", v, (64'hFFFF_FFFF << 26) | 64'h800);

    // oversize count: status kept
    host_wr(2'd0, ctl(1, 4'd8, 32'h0000_0020));
    serve(0, 0, 32'h0000_00A5, 1'b0);
    host_wr(2'd0, ctl(1, 4'd9, 32'h0000_0030));
    repeat (3) @(negedge clk);
    #1 chk("R3 no request for oversize", {63'b0, bus_req_valid}, 64'h0);
    host_rd(2'd2, v); chk("R3 status kept", v, (64'h0000_00A5 << 26) | 64'h800);

    // wrong size ignored
    host_wr(2'd3, 64'h7777_7777_0000_0000, 4'd4);
    host_rd(2'd3, v); chk("R1 size-4 write ignored", v, 64'hA1B2_C3D4_0000_0000);
    host_rd(2'd3, v, 4'd4); chk("R1 size-4 read zero", v, 64'h0);

    // control / reset reads, reset / status writes
    host_rd(2'd0, v); chk("R9 control reads zero", v, 64'h0);
    host_rd(2'd1, v); chk("R9 reset reads zero", v, 64'h0);
    host_wr(2'd0, ctl(0, 4'd0, 32'h0000_0040));
    serve(0, 0, 32'h0, 1'b0);
    host_wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    host_wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    #1 chk("R9 reset write launches nothing", {63'b0, bus_req_valid}, 64'h0);
    host_rd(2'd2, v); chk("R9 status write no effect", v, 64'h800);

    // completion on the same edge as a status read
    host_wr(2'd0, ctl(0, 4'd4, 32'h0000_0050));
    serve(0, 0, 32'h0, 1'b0);
    host_wr(2'd0, ctl(1, 4'd4, 32'h0000_0060));
    #1 while (!bus_req_valid) begin @(negedge clk); #1; end
    bus_req_ready = 1; @(negedge clk); bus_req_ready = 0;
    bus_rsp_valid = 1; bus_rsp_rdata = 32'h0102_0304;
    host_rd(2'd2, v);
    bus_rsp_valid = 0;
    chk("R7 old value on collision", v, 64'h800);
    chk("R11 response taken", {63'b0, bus_rsp_ready}, 64'h0);
    host_rd(2'd2, v); chk("R7 completion wins", v, (64'h0102_0304 << 26) | 64'h800);

    repeat (2) @(negedge clk);
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule